// File: doc/BRIEF.md
# Relocatable Local Scratch RAM

This block is a 4-Kbyte scratch memory that sits on a processor's local bus, held as 1024 words of 32 bits. A base register, written through its own control port, sets the 4-Kbyte aligned page where the memory appears in a 32-bit address space. The same register carries an enable bit, which is clear after reset. While that bit is clear the memory answers no access.

Each local bus access is compared with the base page. When it hits, the block raises `busHit` in the same cycle. A write lands at the closing clock edge, and only on the selected byte lanes. A read captures the whole addressed word at that edge, and the requester keeps the lanes it wants. Bytes are numbered big-endian inside the word.

Top module: `locRamTop`

## Requirements
- R1: While reset is held and after it is released, the enable bit (`baseRdData[0]`) reads 0, `baseRdData[11:1]` reads 0, and no access raises `busHit`.
- R2: A pulse on `baseWrEn` stores `baseWrData[31:12]` as the page field and `baseWrData[0]` as the enable bit. `baseRdData` returns `{page, 11'b0, enable}`, so bits [11:1] always read 0 whatever was written there.
- R3: `busHit` is 1 in a cycle exactly when four things are true: `busValid` is 1, the enable bit is 1, `busAddr[31:12]` equals the page field, and the access is aligned. `busHit` is combinational on the bus inputs.
- R4: A base register write changes the decode only from the cycle after the `baseWrEn` cycle. An access in the write cycle itself is decoded against the old base.
- R5: A word access (`busSize`=2) writes all 32 bits of word `busAddr[11:2]` at the clock edge ending the hit cycle. A word read returns that word on `busRdData` after the same edge.
- R6: A byte access (`busSize`=0) with `busAddr[1:0]`=n changes only byte n of the word. Byte 0 is bits [31:24] and byte 3 is bits [7:0]. The write data is taken from that same lane of `busWrData`.
- R7: A halfword access (`busSize`=1) changes bits [31:16] when `busAddr[1]`=0 and bits [15:0] when `busAddr[1]`=1. The other half is left untouched.
- R8: `busRdData` changes only at the edge that ends a read hit, and it then holds the full addressed word. Writes, misses and idle cycles leave it unchanged.
- R9: An access is not a hit in three cases: a halfword with `busAddr[0]`=1, a word with `busAddr[1:0]`≠0, or any access with `busSize`=3. Such an access does not alter the memory.
- R10: A write that misses, whether to another page or while disabled, does not alter the memory.
- R11: Moving the base to a new page keeps the contents. Word k is then read at new page + 4k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baseWrEn | input | 1 | Base register write strobe |
| baseWrData | input | 32 | Base register write value |
| baseRdData | output | 32 | Base register readback |
| busValid | input | 1 | Local bus access present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| busAddr | input | 32 | Byte address |
| busWrData | input | 32 | Write data, placed in its big-endian lanes |
| busRdData | output | 32 | Read data of the last read hit |
| busHit | output | 1 | Access decodes to this memory |

## Verification
Directed sequences cover the cases that separate one decode error from another. Byte writes to each of the four offsets expose a reversed lane order. Halfword writes to both halves expose a wrong half select. Misaligned and reserved sizes show whether alignment is checked at all. Writes to a foreign page, and writes while disabled, show whether the page compare or the enable bit gates the write strobe. Probing the new page in the same cycle as a base write shows whether the register update is delayed by a cycle. Random traffic then mixes sizes, offsets, hit and miss pages and occasional relocations. It is checked word by word against a bench model, which catches lane merges that corrupt neighbouring bytes and read data that moves on non-read cycles.

// File: rtl/locRamPkg.sv
package locRamPkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 1024;
  localparam int LANES  = DATA_W / 8;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int OFF_W  = $clog2(LANES);
  localparam int PAGE_W = IDX_W + OFF_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_t;

  // Strobes from the decode to the storage; laneMask bit i covers bits [8i+7:8i]
  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [IDX_W-1:0] wordIdx;
    logic [LANES-1:0] laneMask;
  } ramStrobe_t;
endpackage

// File: rtl/locRamCtrl.sv
module locRamCtrl
  import locRamPkg::*;
#(
  parameter int AddrW = ADDR_W,
  parameter int PageW = PAGE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baseWrEn,
  input  logic [AddrW-1:0] baseWrData,
  output logic [AddrW-1:0] baseRdData,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [1:0]       busSize,
  input  logic [AddrW-1:0] busAddr,
  output logic             busHit,
  output ramStrobe_t       strobe
);
  localparam int FieldW = AddrW - PageW;
  localparam logic [AddrW-1:0] KeepMask = {{FieldW{1'b1}}, {(PageW-1){1'b0}}, 1'b1};

  logic [FieldW-1:0] baseField;
  logic              baseValid;
  logic              aligned;
  logic              pageMatch;
  logic [LANES-1:0]  laneSel;
  accSize_t          accSize;
  logic              unusedOk;

  assign unusedOk = ^baseWrData[PageW-1:1];
  assign accSize  = accSize_t'(busSize);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseField <= '0;
      baseValid <= 1'b0;
    end else if (baseWrEn) begin
      baseField <= baseWrData[AddrW-1:PageW];
      baseValid <= baseWrData[0];
    end
  end

  assign baseRdData = {baseField, {(PageW-1){1'b0}}, baseValid};

  always_comb begin
    aligned = 1'b0;
    laneSel = '0;
    unique case (accSize)
      SZ_BYTE: begin
        aligned = 1'b1;
        laneSel = {1'b1, {(LANES-1){1'b0}}} >> busAddr[OFF_W-1:0];
      end
      SZ_HALF: begin
        aligned = !busAddr[0];
        laneSel = busAddr[1] ? {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}}
                             : {{(LANES/2){1'b1}}, {(LANES/2){1'b0}}};
      end
      SZ_WORD: begin
        aligned = (busAddr[OFF_W-1:0] == '0);
        laneSel = '1;
      end
      default: begin
        aligned = 1'b0;
        laneSel = '0;
      end
    endcase
  end

  assign pageMatch = (busAddr[AddrW-1:PageW] == baseField);
  assign busHit    = busValid && baseValid && pageMatch && aligned;

  assign strobe.wrEn     = busHit && busWrite;
  assign strobe.rdEn     = busHit && !busWrite;
  assign strobe.wordIdx  = busAddr[PageW-1:OFF_W];
  assign strobe.laneMask = laneSel;

  // R1
  disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !baseRdData[0] |-> !busHit);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseRdData[PageW-1:1] == '0);
  // R4
  base_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |=> baseRdData == ($past(baseWrData) & KeepMask));
  // R9
  misalign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSize == 2'd3 || (busSize == 2'd2 && busAddr[1:0] != 2'b00)
     || (busSize == 2'd1 && busAddr[0])) |-> !busHit);
  // R6
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busHit && busSize == 2'd0) |-> $countones(strobe.laneMask) == 1);
endmodule

// File: rtl/locRamData.sv
module locRamData
  import locRamPkg::*;
#(
  parameter int DataW = DATA_W,
  parameter int Depth = DEPTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  ramStrobe_t       strobe,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] rdData
);
  localparam int LaneN = DataW / 8;

  logic [DataW-1:0] memArr [Depth];

  for (genvar ln = 0; ln < LaneN; ln++) begin : gLane
    always_ff @(posedge clk) begin
      if (strobe.wrEn && strobe.laneMask[ln])
        memArr[strobe.wordIdx][8*ln +: 8] <= wrData[8*ln +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.rdEn) rdData <= memArr[strobe.wordIdx];
  end

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(rdData));
  // R3
  no_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.rdEn));
endmodule

// File: rtl/locRamTop.sv
module locRamTop
  import locRamPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        baseWrEn,
  input  logic [31:0] baseWrData,
  output logic [31:0] baseRdData,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [1:0]  busSize,
  input  logic [31:0] busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        busHit
);
  ramStrobe_t strobe;

  locRamCtrl #(.AddrW(ADDR_W), .PageW(PAGE_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .baseWrEn(baseWrEn), .baseWrData(baseWrData), .baseRdData(baseRdData),
    .busValid(busValid), .busWrite(busWrite), .busSize(busSize),
    .busAddr(busAddr), .busHit(busHit), .strobe(strobe)
  );

  locRamData #(.DataW(DATA_W), .Depth(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(busWrData), .rdData(busRdData)
  );
endmodule

// File: tb/tb_locRamTop.sv
module tb_locRamTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic [31:0] baseRdData;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busSize = 2'd0;
  logic [31:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        busHit;

  int checks = 0;
  int fails = 0;

  logic [31:0] refMem [1024];
  logic [19:0] refBase = '0;
  logic        refValid = 1'b0;
  logic [31:0] refRd = '0;

  always #2 clk = ~clk;

  locRamTop dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit isAligned(input logic [1:0] sz, input logic [31:0] a);
    case (sz)
      2'd0: return 1'b1;
      2'd1: return !a[0];
      2'd2: return a[1:0] == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit expHit(input logic [1:0] sz, input logic [31:0] a);
    return refValid && (a[31:12] == refBase) && isAligned(sz, a);
  endfunction

  // byte 0 is bits [31:24]
  function automatic logic [31:0] bitMask(input logic [1:0] sz, input logic [31:0] a);
    case (sz)
      2'd0: return 32'hFF00_0000 >> (8 * a[1:0]);
      2'd1: return a[1] ? 32'h0000_FFFF : 32'hFFFF_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic busOp(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] d, input string req);
    bit eh;
    logic [31:0] m;
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busSize = sz; busAddr = a; busWrData = d;
    #1;
    eh = expHit(sz, a);
    chk(busHit === eh, req, "hit", {31'b0, busHit}, {31'b0, eh});
    @(posedge clk); #1;
    busValid = 1'b0;
    if (eh && wr) begin
      m = bitMask(sz, a);
      refMem[a[11:2]] = (refMem[a[11:2]] & ~m) | (d & m);
    end
    if (eh && !wr) refRd = refMem[a[11:2]];
    chk(busRdData === refRd, req, "rdData", busRdData, refRd);
  endtask

  task automatic readWord(input logic [31:0] a, input logic [31:0] exp, input string req);
    busOp(1'b0, 2'd2, a, 32'h0, req);
    chk(busRdData === exp, req, "word value", busRdData, exp);
  endtask

  // probes the new page during the write cycle (old base applies), then after (R4)
  task automatic setBase(input logic [31:0] v);
    bit eh;
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = v;
    busValid = 1'b1; busWrite = 1'b0; busSize = 2'd2; busAddr = {v[31:12], 12'h0};
    #1;
    eh = expHit(2'd2, busAddr);
    chk(busHit === eh, "R4", "hit in write cycle", {31'b0, busHit}, {31'b0, eh});
    @(posedge clk); #1;
    baseWrEn = 1'b0; busValid = 1'b0;
    if (eh) refRd = refMem[0];
    refBase = v[31:12]; refValid = v[0];
    chk(baseRdData === (v & 32'hFFFF_F001), "R2", "readback", baseRdData, v & 32'hFFFF_F001);
    @(negedge clk);
    busValid = 1'b1; #1;
    chk(busHit === v[0], "R4", "hit after write", {31'b0, busHit}, {31'b0, v[0]});
    @(posedge clk); #1;
    busValid = 1'b0;
    if (v[0]) refRd = refMem[0];
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pg;
    void'($urandom(32'h00C0FFEE));
    // R1: during reset
    busValid = 1'b1; busAddr = 32'h0; busSize = 2'd2;
    repeat (3) @(negedge clk);
    chk(busHit === 1'b0, "R1", "hit in reset", {31'b0, busHit}, 32'h0);
    chk(baseRdData[11:0] === 12'h0, "R1", "readback low", baseRdData, 32'h0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(busHit === 1'b0, "R1", "hit after reset", {31'b0, busHit}, 32'h0);
    busValid = 1'b0;

    // R2 reserved bits, R4 delay
    setBase(32'h2000_5AB1);
    pg = 32'h2000_5000;

    // R5 fill
    for (int i = 0; i < 1024; i++)
      busOp(1'b1, 2'd2, pg + 4 * i, (i * 32'h9E37_79B1) ^ 32'h5A5A_0F0F, "R5");
    readWord(pg + 4 * 7, (7 * 32'h9E37_79B1) ^ 32'h5A5A_0F0F, "R5");
    readWord(pg + 4 * 1023, (1023 * 32'h9E37_79B1) ^ 32'h5A5A_0F0F, "R5");

    // R6 byte lanes
    busOp(1'b1, 2'd2, pg + 16, 32'h0000_0000, "R6");
    busOp(1'b1, 2'd0, pg + 16, 32'hAA00_0000, "R6");
    readWord(pg + 16, 32'hAA00_0000, "R6");
    busOp(1'b1, 2'd0, pg + 17, 32'h00BB_0000, "R6");
    busOp(1'b1, 2'd0, pg + 18, 32'h0000_CC00, "R6");
    busOp(1'b1, 2'd0, pg + 19, 32'hFFFF_FFDD, "R6");
    readWord(pg + 16, 32'hAABB_CCDD, "R6");

    // R7 halfwords
    busOp(1'b1, 2'd1, pg + 22, 32'h1234_5678, "R7");
    busOp(1'b1, 2'd2, pg + 20, 32'h0, "R7");
    busOp(1'b1, 2'd1, pg + 22, 32'h1234_5678, "R7");
    readWord(pg + 20, 32'h0000_5678, "R7");
    busOp(1'b1, 2'd1, pg + 20, 32'h9ABC_0000, "R7");
    readWord(pg + 20, 32'h9ABC_5678, "R7");

    // R9 misaligned and reserved size
    busOp(1'b1, 2'd1, pg + 21, 32'hFFFF_FFFF, "R9");
    busOp(1'b1, 2'd2, pg + 22, 32'hFFFF_FFFF, "R9");
    busOp(1'b1, 2'd3, pg + 20, 32'hFFFF_FFFF, "R9");
    readWord(pg + 20, 32'h9ABC_5678, "R9");

    // R10 foreign page; R8 write leaves rdData
    busOp(1'b1, 2'd2, 32'h2000_6014, 32'hDEAD_BEEF, "R10");
    busOp(1'b1, 2'd2, pg + 24, 32'h0BAD_F00D, "R8");
    readWord(pg + 20, 32'h9ABC_5678, "R10");

    // R11 relocation keeps contents
    setBase(32'hFFFF_F001);
    pg = 32'hFFFF_F000;
    readWord(pg + 16, 32'hAABB_CCDD, "R11");
    readWord(pg + 24, 32'h0BAD_F00D, "R11");

    // R3 / R10 disabled
    setBase(32'hFFFF_F000);
    busOp(1'b1, 2'd2, pg + 16, 32'h1111_1111, "R3");
    setBase(32'hFFFF_F001);
    readWord(pg + 16, 32'hAABB_CCDD, "R10");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a;
      logic [1:0] sz;
      if ($urandom % 300 == 0) begin
        setBase({$urandom, 12'h0} | 32'h1);
      end
      sz = 2'($urandom % 4);
      a = {(($urandom % 4) == 0) ? 20'($urandom) : refBase, 12'($urandom)};
      busOp(1'($urandom), sz, a, $urandom, "R3");
    end
    for (int i = 0; i < 1024; i += 61)
      readWord({refBase, 12'h0} + 4 * i, refMem[i], "R5");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule